// File: doc/BRIEF.md
# Associative Tagged SIMD Element Line

This block is a line of simple processing elements that all obey one instruction stream. Each element holds a searchable word, a wider extended store that cannot be searched, and a one-bit tag. A search broadcasts a key and a mask. In a single cycle, every element compares the selected bit positions of its word against the key and writes the result into its tag.

The tags then act as condition flags. A one-bit logic operation changes only elements whose tag is set. A readout walks the tagged elements from the lowest index upward and returns one word and its index per cycle, clearing each tag as it goes. The line is also a shift chain: one chosen bit of every element can move one place toward the higher or the lower index, entering and leaving through a port at each end. A host fills the elements one word at a time through a separate load port.

Top module: `asp_array`

## Requirements
- R1: After synchronous reset, every word, extended store and tag is zero. `busy`, `rd_valid`, `rd_empty`, `link_left_out` and `link_right_out` are low, and `instr_ready` is high.
- R2: Search (opcode 1) sets the tag of each element to 1 when `(word ^ key) & mask` is zero and to 0 otherwise, for every element regardless of its previous tag. A mask bit of 1 puts that position in the compare, so an all-zero mask tags every element. The new tags are in place one cycle after acceptance.
- R3: Logic op (opcode 2) computes f(word[sa], ext[sb]), with fn 0=AND, 1=OR, 2=XOR and 3=NOT of word[sa]. The result goes to ext[sb] when `instr_dst_ext` is 1 and to word[sa] otherwise. It is written only in tagged elements; untagged elements and all tags are left unchanged.
- R4: Readout (opcode 5) returns the tagged elements in ascending index order, one per cycle. The first `rd_valid` appears in the cycle after acceptance, with `rd_index` and `rd_data` holding the element's word. Each returned element's tag is cleared.
- R5: Once no tag remains during a readout, `rd_empty` pulses for one cycle, `busy` falls in the same cycle, and all tags are zero. A readout with no tags gives `rd_empty` in the first cycle after acceptance and no `rd_valid`.
- R6: While `busy` is high, `instr_ready` is low and no instruction is taken.
- R7: Shift-up (opcode 3) moves word[sa] of element i into element i+1. Element 0 takes `link_left_in`, and the bit leaving the last element is registered on `link_right_out`. Shift-down (opcode 4) is the mirror image, using `link_right_in` and `link_left_out`. Shifts act on all elements whatever their tags and change no tag.
- R8: A load writes `ld_data` into element `ld_addr`. `ld_tgt` selects the destination: 0 = word, 1 = ext low half, 2 = ext high half, 3 = nothing.
- R9: `ld_ready` is low while `busy` is high or while `instr_valid` is high. A load offered while `ld_ready` is low writes nothing.
- R10: Tag-all (opcode 6) sets every tag. NOP (opcodes 0 and 7) changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction offered |
| instr_ready | output | 1 | Instruction can be taken |
| instr_op | input | 3 | Opcode |
| instr_key | input | WORD_W | Search key |
| instr_mask | input | WORD_W | Search mask, 1 = compare this bit |
| instr_fn | input | 2 | Logic function select |
| instr_sa | input | clog2(WORD_W) | Word bit select |
| instr_sb | input | clog2(2*WORD_W) | Extended store bit select |
| instr_dst_ext | input | 1 | Logic result goes to extended store |
| ld_valid | input | 1 | Load offered |
| ld_ready | output | 1 | Load can be taken |
| ld_addr | input | clog2(N_PE) | Element to load |
| ld_tgt | input | 2 | Load destination |
| ld_data | input | WORD_W | Load data |
| link_left_in | input | 1 | Bit entering element 0 on shift-up |
| link_left_out | output | 1 | Bit that left element 0 on last shift-down |
| link_right_in | input | 1 | Bit entering last element on shift-down |
| link_right_out | output | 1 | Bit that left last element on last shift-up |
| busy | output | 1 | Readout in progress |
| rd_valid | output | 1 | Readout word valid |
| rd_index | output | clog2(N_PE) | Index of the returned element |
| rd_data | output | WORD_W | Word of the returned element |
| rd_empty | output | 1 | Readout finished, no tags left |

## Verification
The bench builds the line with 8 elements of 16-bit words, so the extended store is 32 bits wide. At that size a word drawn from a small pool of values often equals other words, so random searches tag several elements at once. Full-line dumps (tag-all, then readout) finish in a few cycles, and shifts push bits across both ends of the chain within a short run.

// File: rtl/asp_pkg.sv
package asp_pkg;

  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_SEARCH = 3'd1,
    OP_ALU    = 3'd2,
    OP_SHUP   = 3'd3,
    OP_SHDN   = 3'd4,
    OP_READ   = 3'd5,
    OP_TAGALL = 3'd6,
    OP_IDLE   = 3'd7
  } asp_op_e;

  typedef enum logic [1:0] {
    FN_AND = 2'd0,
    FN_OR  = 2'd1,
    FN_XOR = 2'd2,
    FN_NOT = 2'd3
  } asp_fn_e;

  typedef enum logic [1:0] {
    LD_WORD   = 2'd0,
    LD_EXT_LO = 2'd1,
    LD_EXT_HI = 2'd2,
    LD_NONE   = 2'd3
  } asp_ld_e;

  function automatic logic bit_alu(input logic [1:0] fn, input logic a, input logic b);
    case (asp_fn_e'(fn))
      FN_AND:  return a & b;
      FN_OR:   return a | b;
      FN_XOR:  return a ^ b;
      default: return ~a;
    endcase
  endfunction

endpackage

// File: rtl/asp_pe.sv
module asp_pe
  import asp_pkg::*;
#(
  parameter int WORD_W = 64,
  parameter int EXT_W  = 2 * WORD_W,
  parameter int SA_W   = $clog2(WORD_W),
  parameter int SB_W   = $clog2(EXT_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_we,
  input  logic [1:0]        ld_tgt,
  input  logic [WORD_W-1:0] ld_data,
  input  logic              do_search,
  input  logic              do_alu,
  input  logic              do_shift,
  input  logic              do_tagall,
  input  logic              tag_clr,
  input  logic [WORD_W-1:0] key,
  input  logic [WORD_W-1:0] mask,
  input  logic [1:0]        fn,
  input  logic [SA_W-1:0]   sel_a,
  input  logic [SB_W-1:0]   sel_b,
  input  logic              dst_ext,
  input  logic              shift_in,
  output logic              tag,
  output logic [WORD_W-1:0] word,
  output logic              bit_out
);

  logic [EXT_W-1:0] ext;
  logic             hit;
  logic             alu_res;

  assign hit     = ((word ^ key) & mask) == '0;
  assign alu_res = bit_alu(fn, word[sel_a], ext[sel_b]);
  assign bit_out = word[sel_a];

  always_ff @(posedge clk) begin
    if (rst) begin
      word <= '0;
      ext  <= '0;
      tag  <= 1'b0;
    end else begin
      if (ld_we) begin
        case (asp_ld_e'(ld_tgt))
          LD_WORD:   word <= ld_data;
          LD_EXT_LO: ext[0 +: WORD_W] <= ld_data;
          LD_EXT_HI: ext[WORD_W +: WORD_W] <= ld_data;
          default:   ;
        endcase
      end
      if (do_alu && tag) begin
        if (dst_ext) ext[sel_b] <= alu_res;
        else         word[sel_a] <= alu_res;
      end
      if (do_shift) word[sel_a] <= shift_in;
      if (do_search)      tag <= hit;
      else if (do_tagall) tag <= 1'b1;
      else if (tag_clr)   tag <= 1'b0;
    end
  end

  AST_UNTAGGED_HOLD: assert property (@(posedge clk) disable iff (rst)
    (do_alu && !tag && !ld_we) |=> ($stable(word) && $stable(ext))); // R3

  AST_OPEN_MASK_TAGS: assert property (@(posedge clk) disable iff (rst)
    (do_search && mask == '0) |=> tag); // R2

endmodule

// File: rtl/asp_prio.sv
module asp_prio #(
  parameter int N  = 16,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end

  assign any = |req;

endmodule

// File: rtl/asp_seq.sv
module asp_seq #(
  parameter int WORD_W = 64,
  parameter int IW     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              any,
  input  logic [IW-1:0]     idx,
  input  logic [WORD_W-1:0] sel_word,
  output logic              busy,
  output logic              clr_en,
  output logic              rd_valid,
  output logic [IW-1:0]     rd_index,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_empty
);

  logic reading;

  always_ff @(posedge clk) begin
    if (rst) begin
      reading  <= 1'b0;
      rd_valid <= 1'b0;
      rd_empty <= 1'b0;
      rd_index <= '0;
      rd_data  <= '0;
    end else begin
      rd_valid <= 1'b0;
      rd_empty <= 1'b0;
      if (!reading) begin
        if (start) reading <= 1'b1;
      end else if (any) begin
        rd_valid <= 1'b1;
        rd_index <= idx;
        rd_data  <= sel_word;
      end else begin
        rd_empty <= 1'b1;
        reading  <= 1'b0;
      end
    end
  end

  assign busy   = reading;
  assign clr_en = reading && any;

  AST_EMPTY_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    rd_empty |-> !busy); // R5

  AST_VALID_IN_READ: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> busy); // R6

endmodule

// File: rtl/asp_array.sv
module asp_array
  import asp_pkg::*;
#(
  parameter int N_PE   = 16,
  parameter int WORD_W = 64,
  localparam int EXT_W = 2 * WORD_W,
  localparam int SA_W  = $clog2(WORD_W),
  localparam int SB_W  = $clog2(EXT_W),
  localparam int IW    = (N_PE > 1) ? $clog2(N_PE) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instr_valid,
  output logic              instr_ready,
  input  logic [2:0]        instr_op,
  input  logic [WORD_W-1:0] instr_key,
  input  logic [WORD_W-1:0] instr_mask,
  input  logic [1:0]        instr_fn,
  input  logic [SA_W-1:0]   instr_sa,
  input  logic [SB_W-1:0]   instr_sb,
  input  logic              instr_dst_ext,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [IW-1:0]     ld_addr,
  input  logic [1:0]        ld_tgt,
  input  logic [WORD_W-1:0] ld_data,
  input  logic              link_left_in,
  output logic              link_left_out,
  input  logic              link_right_in,
  output logic              link_right_out,
  output logic              busy,
  output logic              rd_valid,
  output logic [IW-1:0]     rd_index,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_empty
);

  logic              accept;
  logic              do_search, do_alu, do_up, do_dn, do_shift, do_read, do_tagall;
  logic              ld_fire;
  logic [N_PE-1:0]   tag_vec;
  logic [N_PE-1:0]   bit_vec;
  logic [WORD_W-1:0] words [N_PE];
  logic              any_tag;
  logic [IW-1:0]     first_idx;
  logic              clr_en;

  assign instr_ready = !busy;
  assign accept      = instr_valid && !busy;
  assign do_search   = accept && (asp_op_e'(instr_op) == OP_SEARCH);
  assign do_alu      = accept && (asp_op_e'(instr_op) == OP_ALU);
  assign do_up       = accept && (asp_op_e'(instr_op) == OP_SHUP);
  assign do_dn       = accept && (asp_op_e'(instr_op) == OP_SHDN);
  assign do_read     = accept && (asp_op_e'(instr_op) == OP_READ);
  assign do_tagall   = accept && (asp_op_e'(instr_op) == OP_TAGALL);
  assign do_shift    = do_up || do_dn;

  assign ld_ready = !busy && !instr_valid;
  assign ld_fire  = ld_valid && ld_ready;

  for (genvar g = 0; g < N_PE; g++) begin : g_pe
    logic from_low, from_high, sin;
    if (g == 0) begin : g_edge_l
      assign from_low = link_left_in;
    end else begin : g_mid_l
      assign from_low = bit_vec[g-1];
    end
    if (g == N_PE - 1) begin : g_edge_r
      assign from_high = link_right_in;
    end else begin : g_mid_r
      assign from_high = bit_vec[g+1];
    end
    assign sin = do_dn ? from_high : from_low;

    asp_pe #(
      .WORD_W(WORD_W), .EXT_W(EXT_W), .SA_W(SA_W), .SB_W(SB_W)
    ) u_pe (
      .clk      (clk),
      .rst      (rst),
      .ld_we    (ld_fire && (ld_addr == IW'(g))),
      .ld_tgt   (ld_tgt),
      .ld_data  (ld_data),
      .do_search(do_search),
      .do_alu   (do_alu),
      .do_shift (do_shift),
      .do_tagall(do_tagall),
      .tag_clr  (clr_en && (first_idx == IW'(g))),
      .key      (instr_key),
      .mask     (instr_mask),
      .fn       (instr_fn),
      .sel_a    (instr_sa),
      .sel_b    (instr_sb),
      .dst_ext  (instr_dst_ext),
      .shift_in (sin),
      .tag      (tag_vec[g]),
      .word     (words[g]),
      .bit_out  (bit_vec[g])
    );
  end

  asp_prio #(.N(N_PE), .IW(IW)) u_prio (
    .req(tag_vec),
    .any(any_tag),
    .idx(first_idx)
  );

  asp_seq #(.WORD_W(WORD_W), .IW(IW)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .start   (do_read),
    .any     (any_tag),
    .idx     (first_idx),
    .sel_word(words[first_idx]),
    .busy    (busy),
    .clr_en  (clr_en),
    .rd_valid(rd_valid),
    .rd_index(rd_index),
    .rd_data (rd_data),
    .rd_empty(rd_empty)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      link_left_out  <= 1'b0;
      link_right_out <= 1'b0;
    end else begin
      if (do_up) link_right_out <= bit_vec[N_PE-1];
      if (do_dn) link_left_out  <= bit_vec[0];
    end
  end

  AST_READ_CLEARS_TAG: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> !tag_vec[rd_index]); // R4

  AST_EMPTY_NO_TAGS: assert property (@(posedge clk) disable iff (rst)
    rd_empty |-> (tag_vec == '0)); // R5

  AST_ALU_KEEPS_TAGS: assert property (@(posedge clk) disable iff (rst)
    do_alu |=> $stable(tag_vec)); // R3

  AST_SHIFT_KEEPS_TAGS: assert property (@(posedge clk) disable iff (rst)
    do_shift |=> $stable(tag_vec)); // R7

  AST_BUSY_BLOCKS_LOAD: assert property (@(posedge clk) disable iff (rst)
    busy |-> !ld_fire); // R9

endmodule

// File: tb/asp_array_tb.sv
module asp_array_tb;
  localparam int N   = 8;
  localparam int W   = 16;
  localparam int XW  = 2 * W;
  localparam int IW  = $clog2(N);
  localparam int SAW = $clog2(W);
  localparam int SBW = $clog2(XW);

  logic           clk = 1'b0;
  logic           rst;
  logic           instr_valid, instr_ready;
  logic [2:0]     instr_op;
  logic [W-1:0]   instr_key, instr_mask;
  logic [1:0]     instr_fn;
  logic [SAW-1:0] instr_sa;
  logic [SBW-1:0] instr_sb;
  logic           instr_dst_ext;
  logic           ld_valid, ld_ready;
  logic [IW-1:0]  ld_addr;
  logic [1:0]     ld_tgt;
  logic [W-1:0]   ld_data;
  logic           link_left_in, link_left_out, link_right_in, link_right_out;
  logic           busy, rd_valid, rd_empty;
  logic [IW-1:0]  rd_index;
  logic [W-1:0]   rd_data;

  asp_array #(.N_PE(N), .WORD_W(W)) u_dut (.*);

  always #10 clk = ~clk;

  int n_checks = 0;
  int n_err    = 0;
  bit finished = 0;
  bit poking   = 0;

  logic [W-1:0]  m_word [N];
  logic [XW-1:0] m_ext  [N];
  bit            m_tag  [N];
  logic          m_lout, m_rout;
  logic [W-1:0]  pool   [4];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic f_alu(input logic [1:0] fn, input logic a, input logic b);
    case (fn)
      2'd0: return a & b;
      2'd1: return a | b;
      2'd2: return a ^ b;
      default: return ~a;
    endcase
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    if (poking) begin
      instr_valid = 1'b0;
      ld_valid    = 1'b0;
      poking      = 1'b0;
    end
  endtask

  task automatic load(input int a, input logic [1:0] t, input logic [W-1:0] d);
    ld_valid = 1'b1; ld_addr = IW'(a); ld_tgt = t; ld_data = d;
    @(posedge clk);
    @(negedge clk);
    ld_valid = 1'b0;
    case (t)
      2'd0: m_word[a] = d;
      2'd1: m_ext[a][W-1:0] = d;
      2'd2: m_ext[a][XW-1:W] = d;
      default: ;
    endcase
  endtask

  // Issues one non-readout instruction and updates the model.
  task automatic issue(input logic [2:0] op, input logic [W-1:0] key, input logic [W-1:0] mask,
                       input logic [1:0] fn, input int sa, input int sb, input bit dx,
                       input bit lin, input bit rin);
    logic b [N];
    instr_valid = 1'b1; instr_op = op; instr_key = key; instr_mask = mask;
    instr_fn = fn; instr_sa = SAW'(sa); instr_sb = SBW'(sb); instr_dst_ext = dx;
    link_left_in = lin; link_right_in = rin;
    @(posedge clk);
    @(negedge clk);
    instr_valid = 1'b0;
    for (int i = 0; i < N; i++) b[i] = m_word[i][sa];
    case (op)
      3'd1: for (int i = 0; i < N; i++) m_tag[i] = ((m_word[i] ^ key) & mask) == '0;
      3'd2: for (int i = 0; i < N; i++) begin
        if (m_tag[i]) begin
          if (dx) m_ext[i][sb] = f_alu(fn, b[i], m_ext[i][sb]);
          else    m_word[i][sa] = f_alu(fn, b[i], m_ext[i][sb]);
        end
      end
      3'd3: begin
        for (int i = 0; i < N; i++) m_word[i][sa] = (i == 0) ? lin : b[i-1];
        m_rout = b[N-1];
      end
      3'd4: begin
        for (int i = 0; i < N; i++) m_word[i][sa] = (i == N - 1) ? rin : b[i+1];
        m_lout = b[0];
      end
      3'd6: for (int i = 0; i < N; i++) m_tag[i] = 1'b1;
      default: ;
    endcase
    if (op == 3'd3 || op == 3'd4) begin
      check(link_right_out == m_rout, "R7", "link_right_out", 64'(link_right_out), 64'(m_rout));
      check(link_left_out == m_lout, "R7", "link_left_out", 64'(link_left_out), 64'(m_lout));
    end
  endtask

  // Readout; with poke, offers a tag-all and a load while busy (R6, R9).
  task automatic readout(input bit poke);
    instr_valid = 1'b1; instr_op = 3'd5;
    @(posedge clk);
    @(negedge clk);
    instr_valid = 1'b0;
    check(busy == 1'b1, "R6", "busy after readout start", 64'(busy), 64'd1);
    if (poke) begin
      instr_valid = 1'b1; instr_op = 3'd6;
      ld_valid = 1'b1; ld_addr = '0; ld_tgt = 2'd0; ld_data = ~m_word[0];
      poking = 1'b1;
      #1;
      check(instr_ready == 1'b0, "R6", "instr_ready while busy", 64'(instr_ready), 64'd0);
      check(ld_ready == 1'b0, "R9", "ld_ready while busy", 64'(ld_ready), 64'd0);
    end
    for (int i = 0; i < N; i++) begin
      if (m_tag[i]) begin
        step();
        check(rd_valid == 1'b1, "R4", "rd_valid", 64'(rd_valid), 64'd1);
        check(rd_index == IW'(i), "R4", "rd_index", 64'(rd_index), 64'(i));
        check(rd_data == m_word[i], "R4", "rd_data", 64'(rd_data), 64'(m_word[i]));
        check(rd_empty == 1'b0, "R5", "rd_empty early", 64'(rd_empty), 64'd0);
        m_tag[i] = 1'b0;
      end
    end
    step();
    check(rd_empty == 1'b1, "R5", "rd_empty", 64'(rd_empty), 64'd1);
    check(rd_valid == 1'b0, "R5", "rd_valid at end", 64'(rd_valid), 64'd0);
    check(busy == 1'b0, "R5", "busy at end", 64'(busy), 64'd0);
    step();
    check(rd_empty == 1'b0, "R5", "rd_empty one cycle", 64'(rd_empty), 64'd0);
  endtask

  task automatic dump_all();
    issue(3'd6, '0, '0, 2'd0, 0, 0, 1'b0, 1'b0, 1'b0); // R10 tag-all
    readout(1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_err++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    instr_valid = 0; instr_op = 0; instr_key = 0; instr_mask = 0; instr_fn = 0;
    instr_sa = 0; instr_sb = 0; instr_dst_ext = 0; ld_valid = 0; ld_addr = 0;
    ld_tgt = 0; ld_data = 0; link_left_in = 0; link_right_in = 0;
    for (int i = 0; i < N; i++) begin m_word[i] = '0; m_ext[i] = '0; m_tag[i] = 0; end
    m_lout = 0; m_rout = 0;
    pool[0] = 16'h1234; pool[1] = 16'hA5A5; pool[2] = 16'h00FF; pool[3] = 16'h1230;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check(busy == 0, "R1", "busy", 64'(busy), 0);
    check(rd_valid == 0, "R1", "rd_valid", 64'(rd_valid), 0);
    check(rd_empty == 0, "R1", "rd_empty", 64'(rd_empty), 0);
    check(instr_ready == 1, "R1", "instr_ready", 64'(instr_ready), 1);
    check(link_left_out == 0 && link_right_out == 0, "R1", "link outs",
          64'({link_left_out, link_right_out}), 0);
    readout(1'b0);          // R5 no tags after reset
    dump_all();             // R1 words zero

    // R8 loads to every target
    for (int i = 0; i < N; i++) begin
      load(i, 2'd0, pool[i % 4] ^ 16'(i / 4));
      load(i, 2'd1, 16'(i * 16'h1111));
      load(i, 2'd2, ~16'(i));
    end
    load(3, 2'd3, 16'hDEAD); // R8 target 3 writes nothing
    dump_all();

    // R2 open mask tags all, exact key tags subset
    issue(3'd1, 16'hFFFF, '0, 0, 0, 0, 0, 0, 0);
    readout(1'b0);
    issue(3'd1, 16'h1234, 16'hFFFF, 0, 0, 0, 0, 0, 0);
    readout(1'b0);
    issue(3'd1, 16'h1234, 16'hFFF0, 0, 0, 0, 0, 0, 0);
    readout(1'b0);

    // R3 gated logic op: xor ext bit into word bit 15 of tagged only
    issue(3'd1, 16'hA5A5, 16'hFFFE, 0, 0, 0, 0, 0, 0);
    issue(3'd2, 0, 0, 2'd2, 15, 4, 1'b0, 0, 0);
    issue(3'd2, 0, 0, 2'd3, 0, 20, 1'b1, 0, 0);
    issue(3'd2, 0, 0, 2'd1, 1, 20, 1'b0, 0, 0);
    dump_all();

    // R9 load offered with an instruction in the same cycle is dropped
    instr_valid = 1'b1; instr_op = 3'd0;
    ld_valid = 1'b1; ld_addr = 3'd2; ld_tgt = 2'd0; ld_data = 16'hBEEF;
    #1;
    check(ld_ready == 0, "R9", "ld_ready with instr_valid", 64'(ld_ready), 0);
    @(posedge clk);
    @(negedge clk);
    instr_valid = 0; ld_valid = 0;
    dump_all();             // R10 NOP changed nothing, R9 load dropped

    // R7 shifts across both link ports
    issue(3'd3, 0, 0, 0, 5, 0, 0, 1'b1, 1'b0);
    issue(3'd3, 0, 0, 0, 5, 0, 0, 1'b0, 1'b0);
    issue(3'd4, 0, 0, 0, 9, 0, 0, 1'b0, 1'b1);
    issue(3'd1, 0, 0, 0, 0, 0, 0, 0, 0);
    issue(3'd4, 0, 0, 0, 0, 0, 0, 0, 1'b1);
    readout(1'b0);          // R7 tags unchanged by shift
    dump_all();

    // R6/R9 pokes during readout
    issue(3'd1, 16'h0000, 16'h0001, 0, 0, 0, 0, 0, 0);
    readout(1'b1);
    dump_all();

    // Random mix
    for (int it = 0; it < 400; it++) begin
      int sel;
      sel = int'($urandom_range(0, 9));
      case (sel)
        0, 1: load(int'($urandom_range(0, N - 1)), 2'($urandom_range(0, 3)),
                   (($urandom % 2) != 0) ? pool[$urandom % 4] : 16'($urandom));
        2, 3: issue(3'd1, pool[$urandom % 4],
                    (($urandom % 2) != 0) ? 16'hFFFF : 16'($urandom), 0, 0, 0, 0, 0, 0);
        4: issue(3'd2, 0, 0, 2'($urandom), int'($urandom_range(0, W - 1)),
                 int'($urandom_range(0, XW - 1)), 1'($urandom), 0, 0);
        5: issue(3'd3, 0, 0, 0, int'($urandom_range(0, W - 1)), 0, 0, 1'($urandom), 1'($urandom));
        6: issue(3'd4, 0, 0, 0, int'($urandom_range(0, W - 1)), 0, 0, 1'($urandom), 1'($urandom));
        7: issue((($urandom % 2) != 0) ? 3'd0 : 3'd7, 16'($urandom), 16'($urandom), 2'($urandom),
                 0, 0, 0, 0, 0);
        8: readout(1'(($urandom % 4) == 0));
        default: dump_all();
      endcase
    end
    dump_all();

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

endmodule